// File: doc/BRIEF.md
# Trap-Return Privilege and Status Unit

This block holds the processor's current privilege mode and the one 64-bit machine status register. It carries out the three trap-return operations, one each for user, supervisor and machine level. When a return request arrives, the block first checks that the current privilege is at least the level of that return. A legal return does three things. It takes the new privilege mode from the saved previous-privilege field of that level. It copies that level's saved previous-enable bit into its interrupt-enable bit. It then resets the saved fields.

Software reaches the status register through three windows. The machine window sees every field. The supervisor window is a masked view of the same storage, and the user window is a narrower masked view. Interrupt-pending and interrupt-enable registers, which share one bit layout, sit beside them. Read data is registered. The fields that govern memory translation and protection are only stored here; the logic that acts on them lies elsewhere.

Top module: `tru_top`

## Requirements
- R1: After a synchronous reset, `priv_o` is machine (3), `illegal_o` is 0, `csr_rdata` is 0, and the status, pending and enable registers are all zero.
- R2: Privilege codes are user=0, supervisor=1, machine=3. A return to level L is legal only if L is not 2 and the current privilege is at least L. An illegal return raises `illegal_o` for exactly one cycle, in the cycle after the request, and changes no state.
- R3: A legal machine return (level 3) sets the privilege to the 2-bit field at bits 12:11, copies bit 7 into bit 3, sets bit 7 to 1 and clears bits 12:11.
- R4: A legal supervisor return (level 1) sets the privilege to {0, bit 8}, copies bit 5 into bit 1, sets bit 5 to 1 and clears bit 8.
- R5: A legal user return (level 0) sets the privilege to user, copies bit 4 into bit 0 and sets bit 4 to 1.
- R6: The new privilege of a legal return appears on `priv_o` in the cycle after the request.
- R7: `csr_sel`=0 is the machine window. Only bits 35:32, 22:11, 8, 7, 5, 4, 3, 1 and 0 can be written. Writing 2 to bits 12:11 stores 0. All other bits read as 0, except bit 63 (see R10).
- R8: `csr_sel`=1 is the supervisor window. It reads and writes only bits 33:32, 19, 18, 16:13, 8, 5, 4, 1 and 0, and reads bit 63 as well. All other bits read as zero, and writes to them are ignored.
- R9: `csr_sel`=2 is the user window. It reads and writes only bits 4 and 0.
- R10: Bit 63 cannot be written. It reads as 1 when bits 14:13 or bits 16:15 equal 3, and as 0 otherwise.
- R11: `csr_sel`=3 selects interrupt-pending and `csr_sel`=4 selects interrupt-enable. For each, only bits 11, 9, 8, 7, 5, 4, 3, 1 and 0 hold state. Selects 5 to 7 read as zero and ignore writes.
- R12: A return request, legal or not, blocks a status-window write made in the same cycle.
- R13: `csr_rdata` shows the register chosen by `csr_sel` one cycle later, with the contents it held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Trap-return request |
| ret_level | input | 2 | Level of the requested return |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 3 | Register/window select |
| csr_wdata | input | 64 | Write data |
| priv_o | output | 2 | Current privilege mode |
| illegal_o | output | 1 | One-cycle flag for an illegal return |
| csr_rdata | output | 64 | Registered read data |

## Verification
The bench writes all-ones patterns through each window and then reads them back through the other windows. This shows which bits each mask lets through in each direction. Each of the three returns is tried with its saved fields set to different values: a machine return that stays in machine mode, one that drops to supervisor, and supervisor returns with bit 8 both set and cleared. These runs separate restoring the privilege from restoring the enable bit and from resetting the saved fields. Returns from too low a privilege, and with the reserved level, are issued alone and together with a status write. This shows that the flag pulses once and that the write is dropped in both the legal and the illegal case.

// File: rtl/tru_pkg.sv
package tru_pkg;
  localparam int XLEN  = 64;
  localparam int SEL_W = 3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_R = 2'd2;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [SEL_W-1:0] SEL_MWIN = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SWIN = 3'd1;
  localparam logic [SEL_W-1:0] SEL_UWIN = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PEND = 3'd3;
  localparam logic [SEL_W-1:0] SEL_ENAB = 3'd4;

  // status field positions
  localparam int B_DIRTY = XLEN - 1;
  localparam int B_SXL   = 34;
  localparam int B_UXL   = 32;
  localparam int B_TSR   = 22;
  localparam int B_TW    = 21;
  localparam int B_TVM   = 20;
  localparam int B_MXR   = 19;
  localparam int B_SUM   = 18;
  localparam int B_MPRV  = 17;
  localparam int B_XS    = 15;
  localparam int B_FS    = 13;
  localparam int B_MPP   = 11;
  localparam int B_SPP   = 8;
  localparam int B_MPIE  = 7;
  localparam int B_SPIE  = 5;
  localparam int B_UPIE  = 4;
  localparam int B_MIE   = 3;
  localparam int B_SIE   = 1;
  localparam int B_UIE   = 0;

  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] TWO = {{(XLEN-2){1'b0}}, 2'b11};

  localparam logic [XLEN-1:0] USR_MASK = (ONE << B_UPIE) | (ONE << B_UIE);
  localparam logic [XLEN-1:0] SUP_WMASK = USR_MASK | (TWO << B_UXL) | (ONE << B_MXR) |
      (ONE << B_SUM) | (TWO << B_XS) | (TWO << B_FS) | (ONE << B_SPP) |
      (ONE << B_SPIE) | (ONE << B_SIE);
  localparam logic [XLEN-1:0] SUP_RMASK = SUP_WMASK | (ONE << B_DIRTY);
  localparam logic [XLEN-1:0] MCH_WMASK = SUP_WMASK | (TWO << B_SXL) | (ONE << B_TSR) |
      (ONE << B_TW) | (ONE << B_TVM) | (ONE << B_MPRV) | (TWO << B_MPP) |
      (ONE << B_MPIE) | (ONE << B_MIE);
  // interrupt layout: external 11/9/8, timer 7/5/4, software 3/1/0
  localparam logic [XLEN-1:0] IRQ_MASK = (ONE << 11) | (ONE << 9) | (ONE << 8) |
      (ONE << 7) | (ONE << 5) | (ONE << 4) | (ONE << 3) | (ONE << 1) | ONE;
  localparam logic [XLEN-1:0] RET_FIELDS = (TWO << B_MPP) | (ONE << B_SPP) |
      (ONE << B_MPIE) | (ONE << B_SPIE) | (ONE << B_UPIE) | (ONE << B_MIE) |
      (ONE << B_SIE) | (ONE << B_UIE);
endpackage

// File: rtl/tru_ret_ctrl.sv
module tru_ret_ctrl
  import tru_pkg::*;
(
  input  logic            ret_valid,
  input  logic [1:0]      ret_level,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] status_i,
  output logic            do_ret,
  output logic            bad_ret,
  output logic [1:0]      priv_nxt,
  output logic [XLEN-1:0] status_nxt
);
  logic allowed;

  always_comb begin
    allowed    = (ret_level != PRIV_R) && (priv_i >= ret_level);
    priv_nxt   = priv_i;
    status_nxt = status_i;
    case (ret_level)
      PRIV_M: begin
        priv_nxt                      = status_i[B_MPP+1:B_MPP];
        status_nxt[B_MIE]             = status_i[B_MPIE];
        status_nxt[B_MPIE]            = 1'b1;
        status_nxt[B_MPP+1:B_MPP]     = PRIV_U;
      end
      PRIV_S: begin
        priv_nxt           = {1'b0, status_i[B_SPP]};
        status_nxt[B_SIE]  = status_i[B_SPIE];
        status_nxt[B_SPIE] = 1'b1;
        status_nxt[B_SPP]  = 1'b0;
      end
      default: begin
        priv_nxt           = PRIV_U;
        status_nxt[B_UIE]  = status_i[B_UPIE];
        status_nxt[B_UPIE] = 1'b1;
      end
    endcase
    do_ret  = ret_valid && allowed;
    bad_ret = ret_valid && !allowed;
  end
endmodule

// File: rtl/tru_wr_merge.sv
module tru_wr_merge
  import tru_pkg::*;
(
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  wdata,
  input  logic [XLEN-1:0]  status_i,
  input  logic [XLEN-1:0]  pend_i,
  input  logic [XLEN-1:0]  enab_i,
  output logic             status_we,
  output logic             pend_we,
  output logic             enab_we,
  output logic [XLEN-1:0]  status_new,
  output logic [XLEN-1:0]  pend_new,
  output logic [XLEN-1:0]  enab_new
);
  logic [XLEN-1:0] wmask;

  always_comb begin
    case (sel)
      SEL_MWIN: wmask = MCH_WMASK;
      SEL_SWIN: wmask = SUP_WMASK;
      SEL_UWIN: wmask = USR_MASK;
      default:  wmask = '0;
    endcase
    status_new = (status_i & ~wmask) | (wdata & wmask);
    if (sel == SEL_MWIN && wdata[B_MPP+1:B_MPP] == PRIV_R)
      status_new[B_MPP+1:B_MPP] = PRIV_U;
    pend_new  = wdata & IRQ_MASK;
    enab_new  = wdata & IRQ_MASK;
    status_we = we && (sel == SEL_MWIN || sel == SEL_SWIN || sel == SEL_UWIN);
    pend_we   = we && (sel == SEL_PEND);
    enab_we   = we && (sel == SEL_ENAB);
  end
endmodule

// File: rtl/tru_view.sv
module tru_view
  import tru_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  status_i,
  input  logic [XLEN-1:0]  pend_i,
  input  logic [XLEN-1:0]  enab_i,
  output logic [XLEN-1:0]  rdata
);
  logic            dirty;
  logic [XLEN-1:0] full;

  always_comb begin
    dirty = (status_i[B_FS+1:B_FS] == 2'b11) || (status_i[B_XS+1:B_XS] == 2'b11);
    full  = status_i;
    full[B_DIRTY] = dirty;
    case (sel)
      SEL_MWIN: rdata = full;
      SEL_SWIN: rdata = full & SUP_RMASK;
      SEL_UWIN: rdata = full & USR_MASK;
      SEL_PEND: rdata = pend_i;
      SEL_ENAB: rdata = enab_i;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tru_top.sv
module tru_top
  import tru_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ret_valid,
  input  logic [1:0]       ret_level,
  input  logic             csr_we,
  input  logic [SEL_W-1:0] csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [1:0]       priv_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  csr_rdata
);
  logic [XLEN-1:0] status_q, pend_q, enab_q, rdata_q;
  logic [1:0]      priv_q;
  logic            illegal_q;

  logic            do_ret, bad_ret, status_we, pend_we, enab_we;
  logic [1:0]      ret_priv;
  logic [XLEN-1:0] ret_status, wr_status, wr_pend, wr_enab, view_data;

  tru_ret_ctrl u_ret (
    .ret_valid (ret_valid), .ret_level (ret_level), .priv_i (priv_q),
    .status_i  (status_q),  .do_ret    (do_ret),    .bad_ret (bad_ret),
    .priv_nxt  (ret_priv),  .status_nxt(ret_status)
  );

  tru_wr_merge u_wr (
    .we        (csr_we),    .sel       (csr_sel),   .wdata    (csr_wdata),
    .status_i  (status_q),  .pend_i    (pend_q),    .enab_i   (enab_q),
    .status_we (status_we), .pend_we   (pend_we),   .enab_we  (enab_we),
    .status_new(wr_status), .pend_new  (wr_pend),   .enab_new (wr_enab)
  );

  tru_view u_view (
    .sel(csr_sel), .status_i(status_q), .pend_i(pend_q), .enab_i(enab_q),
    .rdata(view_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      pend_q    <= '0;
      enab_q    <= '0;
      rdata_q   <= '0;
      priv_q    <= PRIV_M;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= bad_ret;
      rdata_q   <= view_data;
      if (do_ret) begin
        status_q <= ret_status;
        priv_q   <= ret_priv;
      end else if (!ret_valid && status_we) begin
        status_q <= wr_status;
      end
      if (pend_we) pend_q <= wr_pend;
      if (enab_we) enab_q <= wr_enab;
    end
  end

  assign priv_o    = priv_q;
  assign illegal_o = illegal_q;
  assign csr_rdata = rdata_q;

  // R2
  bad_ret_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && (ret_level == PRIV_R || ret_level > priv_q))
    |=> (illegal_o && $stable(status_q) && $stable(priv_q)));

  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(ret_valid));

  // R3
  mret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_level == PRIV_M && priv_q == PRIV_M)
    |=> (priv_o == $past(status_q[B_MPP+1:B_MPP]) && status_q[B_MIE] == $past(status_q[B_MPIE])
         && status_q[B_MPIE] && status_q[B_MPP+1:B_MPP] == PRIV_U));

  // R4
  sret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_level == PRIV_S && priv_q != PRIV_U)
    |=> (priv_o == {1'b0, $past(status_q[B_SPP])} && status_q[B_SIE] == $past(status_q[B_SPIE])
         && status_q[B_SPIE] && !status_q[B_SPP]));

  // R5
  uret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_level == PRIV_U)
    |=> (priv_o == PRIV_U && status_q[B_UIE] == $past(status_q[B_UPIE]) && status_q[B_UPIE]));

  // R12
  write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> ((status_q & ~RET_FIELDS) == $past(status_q & ~RET_FIELDS)));
endmodule

// File: tb/tb_tru_top.sv
module tb_tru_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_level = 2'd0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_sel = 3'd0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  priv_o;
  logic        illegal_o;
  logic [63:0] csr_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [63:0] m_st = '0, m_ip = '0, m_ie = '0, m_rd = '0;
  logic [1:0]  m_priv = 2'd3;
  logic        m_ill = 1'b0;

  localparam logic [63:0] K_M = 64'h0000_000F_007F_F9BB;
  localparam logic [63:0] K_S = 64'h0000_0003_000D_E133;
  localparam logic [63:0] K_U = 64'h0000_0000_0000_0011;
  localparam logic [63:0] K_I = 64'h0000_0000_0000_0BBB;
  localparam logic [63:0] ALL = {64{1'b1}};

  tru_top dut (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_level(ret_level),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .priv_o(priv_o), .illegal_o(illegal_o), .csr_rdata(csr_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] see(input logic [2:0] s);
    logic [63:0] f;
    f = m_st;
    f[63] = (m_st[14:13] == 2'd3) || (m_st[16:15] == 2'd3);
    case (s)
      3'd0: return f;
      3'd1: return f & (K_S | (64'd1 << 63));
      3'd2: return f & K_U;
      3'd3: return m_ip;
      3'd4: return m_ie;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "priv", {62'd0, priv_o}, {62'd0, m_priv});
    check(tag, "illegal", {63'd0, illegal_o}, {63'd0, m_ill});
    check(tag, "rdata", csr_rdata, m_rd);
  endtask

  task automatic step(input bit rv, input logic [1:0] rl, input bit we, input logic [2:0] sel,
                      input logic [63:0] wd, input string tag);
    logic [63:0] k;
    bit ok;
    @(negedge clk);
    ret_valid = rv; ret_level = rl; csr_we = we; csr_sel = sel; csr_wdata = wd;
    @(posedge clk);
    m_rd  = see(sel);
    ok    = (rl != 2'd2) && (rl <= m_priv);
    m_ill = rv && !ok;
    if (rv && ok) begin
      if (rl == 2'd3) begin
        m_priv = m_st[12:11]; m_st[3] = m_st[7]; m_st[7] = 1'b1; m_st[12:11] = 2'd0;
      end else if (rl == 2'd1) begin
        m_priv = {1'b0, m_st[8]}; m_st[1] = m_st[5]; m_st[5] = 1'b1; m_st[8] = 1'b0;
      end else begin
        m_priv = 2'd0; m_st[0] = m_st[4]; m_st[4] = 1'b1;
      end
    end else if (!rv && we && sel <= 3'd2) begin
      k = (sel == 3'd0) ? K_M : (sel == 3'd1) ? K_S : K_U;
      m_st = (m_st & ~k) | (wd & k);
      if (sel == 3'd0 && wd[12:11] == 2'd2) m_st[12:11] = 2'd0;
    end
    if (we && sel == 3'd3) m_ip = wd & K_I;
    if (we && sel == 3'd4) m_ie = wd & K_I;
    #1;
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d, input string tag);
    step(0, 2'd0, 1, s, d, tag);
  endtask
  task automatic rd(input logic [2:0] s, input string tag);
    step(0, 2'd0, 0, s, 64'd0, tag);
  endtask
  task automatic rt(input logic [1:0] l, input string tag);
    step(1, l, 0, 3'd0, 64'd0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1; compare("R1");
    rd(3'd3, "R1"); rd(3'd0, "R1");

    // machine window masks and read latency
    wr(3'd0, ALL, "R7"); rd(3'd0, "R7"); rd(3'd0, "R13");
    rd(3'd1, "R8"); rd(3'd2, "R9");
    wr(3'd0, 64'd2 << 11, "R7"); rd(3'd0, "R7");
    // supervisor and user windows
    wr(3'd0, 64'd0, "R8"); wr(3'd1, ALL, "R8"); rd(3'd0, "R8"); rd(3'd1, "R8");
    wr(3'd0, 64'd0, "R9"); wr(3'd2, ALL, "R9"); rd(3'd0, "R9"); rd(3'd2, "R9");
    // dirty summary bit
    wr(3'd0, 64'd3 << 13, "R10"); rd(3'd0, "R10"); rd(3'd1, "R10");
    wr(3'd0, 64'd3 << 15, "R10"); rd(3'd0, "R10");
    wr(3'd0, (64'd1 << 63) | (64'd1 << 13), "R10"); rd(3'd0, "R10");
    // interrupt registers
    wr(3'd3, ALL, "R11"); rd(3'd3, "R11"); wr(3'd4, ALL, "R11"); rd(3'd4, "R11");
    wr(3'd5, ALL, "R11"); rd(3'd5, "R11"); rd(3'd3, "R11");
    wr(3'd4, 64'h0A0, "R11"); rd(3'd4, "R11");

    // return beats a same-cycle status write
    wr(3'd0, (64'd3 << 11) | (64'd1 << 7), "R12");
    step(1, 2'd3, 1, 3'd0, ALL, "R12"); rd(3'd0, "R12");
    // machine return to supervisor
    wr(3'd0, (64'd1 << 11) | (64'd1 << 3) | (64'd1 << 8) | (64'd1 << 5), "R3");
    rt(2'd3, "R6"); rd(3'd0, "R3");
    // supervisor returns
    rt(2'd1, "R4"); rd(3'd0, "R4");
    wr(3'd1, 64'd1 << 1, "R4"); rt(2'd1, "R4"); rd(3'd0, "R4");
    // illegal returns from user mode
    rt(2'd3, "R2"); rd(3'd0, "R2"); rt(2'd1, "R2"); rt(2'd2, "R2"); rd(3'd0, "R2");
    // user return
    wr(3'd2, 64'd1 << 4, "R5"); rt(2'd0, "R5"); rd(3'd2, "R5");
    wr(3'd2, 64'd0, "R5"); rt(2'd0, "R5"); rd(3'd2, "R5");
    // illegal return still blocks the write
    step(1, 2'd3, 1, 3'd2, 64'd0, "R12"); rd(3'd2, "R12");
    step(1, 2'd2, 1, 3'd0, ALL, "R12"); rd(3'd0, "R12");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule